// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words. The writer and the reader run on clocks with no fixed relation between them. The storage depth is a power of two set by a parameter. Each side counts positions with a binary pointer. The pointer crosses to the other clock domain as a Gray code, through a synchronizer chain whose length is a parameter. The write side builds its own flags from its pointer and the synchronized read pointer, and the read side does the same the other way round.

All flags are active low. Empty and almost-empty belong to the read clock. Full, almost-full and half-full belong to the write clock. The two threshold flags compare the fill level against two offset values. A separate offset-programming block drives these offsets and holds them, so a reset of this block never alters them.

There are two reset inputs: a master reset and a partial reset. Either one returns both pointers to the first location, and the flags are then derived again from the offsets present at the inputs. A rewind input, sampled low on a read-clock edge, sets the read pointer back to the first location. The write pointer does not move, so data already written can be read a second time.

Top module: `dcf_pflag_fifo`

## Requirements
- R1: Every accepted word leaves `rd_data` in the order it was written. A read is accepted when `rd_en_n` is low, `rewind_n` is high and `empty_n` is high at a rising `rd_clk` edge. The word appears on `rd_data` right after that edge.
- R2: Once both pointers have settled across the clock domains, `empty_n` is low exactly when the fill level is 0, and `full_n` is low exactly when the fill level equals DEPTH (16 by default).
- R3: Once settled, `aempty_n` is low exactly when the fill level is less than or equal to `ae_ofs`.
- R4: Once settled, `afull_n` is low exactly when DEPTH minus the fill level is less than or equal to `af_ofs`.
- R5: Once settled, `half_n` is low exactly when the fill level is greater than DEPTH/2.
- R6: A write with `wr_en_n` low while `full_n` is low is dropped. It leaves the write pointer, the stored words and the flags unchanged.
- R7: A read with `rd_en_n` low while `empty_n` is low is dropped. It leaves the read pointer unchanged, and `rd_data` keeps its last value.
- R8: While `mrst_n` is low, both pointers are at the first location and `rd_data` is 0. The flags show an empty buffer: `empty_n`=0, `aempty_n`=0, `half_n`=1, `full_n`=1, and `afull_n`=1 when `af_ofs` is below DEPTH.
- R9: A low level on `prst_n` empties the buffer in the same way as R8. The flags that follow are computed with the offsets present at the inputs, including non-default ones.
- R10: A low `rewind_n` at a rising `rd_clk` edge sets the read pointer to the first location and does not move the write pointer. The words are then read again from the first one. This is valid when no more than DEPTH words have been written since the last reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, asynchronous assert |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DATA_W | Registered output word |
| rewind_n | input | 1 | Rewind read pointer to first location, active low |
| ae_ofs | input | ADDR_W | Almost-empty threshold (read domain, quasi-static) |
| af_ofs | input | ADDR_W | Almost-full threshold (write domain, quasi-static) |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| half_n | output | 1 | More than half full, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
A pointer that is corrupted or stuck would appear at the ports as a word out of order or repeated on `rd_data` at the very next accepted read. A Gray code that is wrong, or a chain that does not synchronize, would instead give a flag that stays wrong after a few cycles of the other clock. The bench therefore fills and drains the buffer one word at a time, lets the crossing settle, and checks all five flags at every fill level from 0 to DEPTH. It repeats this under a second pair of offsets after a partial reset. Free-running streams on unrelated clocks, throttled first on one side and then on the other, check the data order. A rewind after a partial fill must return the first words again, and the next write must land after them.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   localparam int unsigned CODE_W = 32;

   function automatic logic [CODE_W-1:0] bin2gray(input logic [CODE_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
      logic [CODE_W-1:0] b;
      b[CODE_W-1] = g[CODE_W-1];
      for (int i = CODE_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int unsigned W      = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
   parameter int unsigned DW = 9,
   parameter int unsigned AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] ram [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) ram[waddr] <= wdata;
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n)  rdata <= '0;
      else if (re)  rdata <= ram[raddr];
   end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_n,
   input  logic [AW:0]   rgray_s,
   input  logic [AW-1:0] af_ofs,
   output logic [AW:0]   wptr_bin,
   output logic [AW:0]   wptr_gray,
   output logic [AW-1:0] waddr,
   output logic          mem_we,
   output logic          full_n,
   output logic          afull_n,
   output logic          half_n
);
   localparam int unsigned DEPTH   = 1 << AW;
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
   localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

   logic [AW:0] rsync_bin;
   logic [AW:0] fill;
   logic [AW:0] room;
   logic [AW:0] wnext;

   always_comb begin
      rsync_bin = (AW+1)'(gray2bin(CODE_W'(rgray_s)));
      fill      = wptr_bin - rsync_bin;
      room      = DEPTH_V - fill;
      full_n    = (fill != DEPTH_V);
      afull_n   = !(room <= {1'b0, af_ofs});
      half_n    = !(fill > HALF_V);
      mem_we    = !wr_en_n && full_n;
      wnext     = wptr_bin + (AW+1)'(mem_we);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_bin  <= '0;
         wptr_gray <= '0;
      end else begin
         wptr_bin  <= wnext;
         wptr_gray <= (AW+1)'(bin2gray(CODE_W'(wnext)));
      end
   end

   assign waddr = wptr_bin[AW-1:0];
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
   import dcf_pkg::*;
#(
   parameter int unsigned AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en_n,
   input  logic          rewind_n,
   input  logic [AW:0]   wgray_s,
   input  logic [AW-1:0] ae_ofs,
   output logic [AW:0]   rptr_bin,
   output logic [AW:0]   rptr_gray,
   output logic [AW-1:0] raddr,
   output logic          mem_re,
   output logic          empty_n,
   output logic          aempty_n
);
   logic [AW:0] wsync_bin;
   logic [AW:0] fill;
   logic [AW:0] rnext;

   always_comb begin
      wsync_bin = (AW+1)'(gray2bin(CODE_W'(wgray_s)));
      fill      = wsync_bin - rptr_bin;
      empty_n   = (fill != '0);
      aempty_n  = !(fill <= {1'b0, ae_ofs});
      mem_re    = !rd_en_n && rewind_n && empty_n;
      if (!rewind_n) rnext = '0;
      else           rnext = rptr_bin + (AW+1)'(mem_re);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_bin  <= '0;
         rptr_gray <= '0;
      end else begin
         rptr_bin  <= rnext;
         rptr_gray <= (AW+1)'(bin2gray(CODE_W'(rnext)));
      end
   end

   assign raddr = rptr_bin[AW-1:0];
endmodule

// File: rtl/dcf_pflag_fifo.sv
module dcf_pflag_fifo #(
   parameter int unsigned DATA_W      = 9,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              wr_en_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en_n,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rewind_n,
   input  logic [ADDR_W-1:0] ae_ofs,
   input  logic [ADDR_W-1:0] af_ofs,
   output logic              empty_n,
   output logic              aempty_n,
   output logic              half_n,
   output logic              afull_n,
   output logic              full_n
);
   localparam int unsigned PTR_W = ADDR_W + 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("dcf_pflag_fifo: DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 20) begin : g_bad_addr_w
      $error("dcf_pflag_fifo: ADDR_W must lie in 2..20");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcf_pflag_fifo: SYNC_STAGES must be at least 2");
   end

   logic             arst_n;
   logic             wr_rst_n;
   logic             rd_rst_n;
   logic [PTR_W-1:0] wptr_bin, wptr_gray, wgray_s;
   logic [PTR_W-1:0] rptr_bin, rptr_gray, rgray_s;
   logic [ADDR_W-1:0] waddr, raddr;
   logic             mem_we, mem_re;

   assign arst_n = mrst_n & prst_n;

   dcf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
      .clk(wr_clk), .arst_n(arst_n), .rst_n(wr_rst_n));
   dcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
      .clk(rd_clk), .arst_n(arst_n), .rst_n(rd_rst_n));

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wptr_gray), .q(wgray_s));
   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rptr_gray), .q(rgray_s));

   dcf_wr_ctl #(.AW(ADDR_W)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .wr_en_n(wr_en_n), .rgray_s(rgray_s),
      .af_ofs(af_ofs), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
      .waddr(waddr), .mem_we(mem_we), .full_n(full_n), .afull_n(afull_n),
      .half_n(half_n));

   dcf_rd_ctl #(.AW(ADDR_W)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
      .wgray_s(wgray_s), .ae_ofs(ae_ofs), .rptr_bin(rptr_bin),
      .rptr_gray(rptr_gray), .raddr(raddr), .mem_re(mem_re),
      .empty_n(empty_n), .aempty_n(aempty_n));

   dcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
      .wclk(wr_clk), .we(mem_we), .waddr(waddr), .wdata(wr_data),
      .rclk(rd_clk), .rrst_n(rd_rst_n), .re(mem_re), .raddr(raddr),
      .rdata(rd_data));
endmodule

// File: rtl/dcf_pflag_chk.sv
module dcf_pflag_chk #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 9
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          wr_rst_n,
   input logic          rd_rst_n,
   input logic          wr_en_n,
   input logic          rd_en_n,
   input logic          rewind_n,
   input logic          full_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic [AW:0]   wptr_bin,
   input logic [AW:0]   wptr_gray,
   input logic [AW:0]   rptr_bin,
   input logic [DW-1:0] rd_data
);
   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (!full_n && !wr_en_n) |=> $stable(wptr_bin)); // R6

   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (!empty_n && !rd_en_n && rewind_n) |=> ($stable(rptr_bin) && $stable(rd_data))); // R7

   AST_READ_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (empty_n && !rd_en_n && rewind_n) |=> (rptr_bin == (AW+1)'($past(rptr_bin) + 1'b1))); // R1

   AST_REWIND_START: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !rewind_n |=> (rptr_bin == '0)); // R10

   AST_GRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $onehot0(wptr_gray ^ $past(wptr_gray))); // R1

   AST_FULL_HAS_AFULL: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      !full_n |-> !afull_n); // R4

   AST_EMPTY_HAS_AEMPTY: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      !empty_n |-> !aempty_n); // R3
endmodule

bind dcf_pflag_fifo dcf_pflag_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
   .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
   .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
   .wptr_bin(wptr_bin), .wptr_gray(wptr_gray), .rptr_bin(rptr_bin),
   .rd_data(rd_data));

// File: tb/dcf_pflag_fifo_tb.sv
`timescale 1ns/100ps
module dcf_pflag_fifo_tb;
   localparam int DW = 9;
   localparam int AW = 4;
   localparam int D  = 1 << AW;

   logic          wr_clk = 0, rd_clk = 0;
   logic          mrst_n, prst_n, wr_en_n, rd_en_n, rewind_n;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] ae_ofs, af_ofs;
   logic          empty_n, aempty_n, half_n, afull_n, full_n;

   int errs = 0, checks = 0;
   int hist [1024];
   int wi = 0, ri = 0;
   int last_rd = 0;
   bit done = 0;

   always #5   wr_clk = ~wr_clk;
   always #6.5 rd_clk = ~rd_clk;

   dcf_pflag_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
      .rd_data(rd_data), .rewind_n(rewind_n), .ae_ofs(ae_ofs),
      .af_ofs(af_ofs), .empty_n(empty_n), .aempty_n(aempty_n),
      .half_n(half_n), .afull_n(afull_n), .full_n(full_n));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge wr_clk);
      repeat (8) @(negedge rd_clk);
   endtask

   task automatic check_flags(input int c, input string pfx);
      int e_em, e_ae, e_hf, e_af, e_fu;
      e_em = (c != 0);
      e_ae = !(c <= int'(ae_ofs));
      e_hf = !(c > D / 2);
      e_af = !((D - c) <= int'(af_ofs));
      e_fu = (c != D);
      chk(empty_n  == e_em, {pfx, " R2 empty_n"},  empty_n,  e_em);
      chk(aempty_n == e_ae, {pfx, " R3 aempty_n"}, aempty_n, e_ae);
      chk(half_n   == e_hf, {pfx, " R5 half_n"},   half_n,   e_hf);
      chk(afull_n  == e_af, {pfx, " R4 afull_n"},  afull_n,  e_af);
      chk(full_n   == e_fu, {pfx, " R2 full_n"},   full_n,   e_fu);
   endtask

   task automatic wr_word(input int d);
      @(negedge wr_clk);
      wr_en_n = 0;
      wr_data = DW'(d);
      @(negedge wr_clk);
      wr_en_n = 1;
      if (wi - ri < D) begin
         hist[wi] = d & 511;
         wi++;
      end
   endtask

   task automatic rd_word(input string tag);
      @(negedge rd_clk);
      rd_en_n = 0;
      @(negedge rd_clk);
      rd_en_n = 1;
      if (wi - ri > 0) begin
         chk(int'(rd_data) == hist[ri], tag, int'(rd_data), hist[ri]);
         last_rd = int'(rd_data);
         ri++;
      end else begin
         chk(int'(rd_data) == last_rd, "R7 rd_data held on empty read", int'(rd_data), last_rd);
      end
   endtask

   task automatic hit_reset(input bit partial);
      if (partial) prst_n = 0; else mrst_n = 0;
      repeat (4) @(negedge wr_clk);
      repeat (4) @(negedge rd_clk);
      wi = 0; ri = 0; last_rd = 0;
      if (partial) begin
         check_flags(0, "R9 during partial reset");
         chk(rd_data == 0, "R9 rd_data cleared", int'(rd_data), 0);
      end else begin
         check_flags(0, "R8 during master reset");
         chk(rd_data == 0, "R8 rd_data cleared", int'(rd_data), 0);
      end
      prst_n = 1; mrst_n = 1;
      settle();
      check_flags(0, partial ? "R9 after partial reset" : "R8 after master reset");
   endtask

   task automatic sweep(input int base, input string pfx);
      for (int lvl = 1; lvl <= D; lvl++) begin
         wr_word(lvl * 37 + base);
         settle();
         check_flags(wi - ri, pfx);
      end
      wr_word(9'h1AA);
      settle();
      check_flags(D, "R6 write while full");
      chk(wi - ri == D, "R6 model level", wi - ri, D);
      for (int lvl = D - 1; lvl >= 0; lvl--) begin
         rd_word("R1 sweep data");
         settle();
         check_flags(wi - ri, pfx);
      end
      rd_word("R7 read while empty");
      settle();
      check_flags(0, "R7 flags after empty read");
      wr_word(9'h055);
      settle();
      rd_word("R7 pointer kept after empty read");
   endtask

   task automatic stream(input int n, input logic [15:0] wmask, input logic [15:0] rmask);
      fork
         begin
            int sent = 0;
            logic [15:0] lf = 16'hACE1;
            while (sent < n) begin
               @(negedge wr_clk);
               lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
               if (full_n && ((lf & wmask) == 0)) begin
                  wr_en_n = 0;
                  wr_data = DW'(sent * 13 + 5);
                  hist[wi] = (sent * 13 + 5) & 511;
                  wi++;
                  sent++;
               end else begin
                  wr_en_n = 1;
               end
            end
            @(negedge wr_clk);
            wr_en_n = 1;
         end
         begin
            int got = 0;
            bit pend = 0;
            logic [15:0] lf = 16'h1D2B;
            while (got < n) begin
               @(negedge rd_clk);
               lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
               if (pend) begin
                  chk(int'(rd_data) == hist[ri], "R1 stream order", int'(rd_data), hist[ri]);
                  last_rd = int'(rd_data);
                  ri++;
                  got++;
                  pend = 0;
               end
               if (got < n && empty_n && ((lf & rmask) == 0)) begin
                  rd_en_n = 0;
                  pend = 1;
               end else begin
                  rd_en_n = 1;
               end
            end
         end
      join
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      mrst_n = 0; prst_n = 1; wr_en_n = 1; rd_en_n = 1; rewind_n = 1;
      wr_data = '0; ae_ofs = 4'd2; af_ofs = 4'd2;

      // R8: master reset from power-up
      hit_reset(1'b0);

      // R2 R3 R4 R5 R6 R7 with offsets 2/2
      sweep(3, "offsets 2/2");

      // R1: unrelated clocks, reader throttled, then writer throttled
      stream(200, 16'h0000, 16'h0003);
      stream(200, 16'h0003, 16'h0000);
      settle();
      check_flags(0, "R2 after streams");

      // R10: rewind after a partial fill
      hit_reset(1'b0);
      for (int k = 0; k < 5; k++) wr_word(100 + k * 11);
      settle();
      for (int k = 0; k < 3; k++) rd_word("R10 first pass");
      settle();
      check_flags(2, "R10 before rewind");
      @(negedge rd_clk); rewind_n = 0;
      @(negedge rd_clk); rewind_n = 1;
      ri = 0;
      settle();
      check_flags(5, "R10 after rewind");
      for (int k = 0; k < 5; k++) rd_word("R10 reread data");
      wr_word(9'h133);
      settle();
      check_flags(1, "R10 write pointer kept");
      rd_word("R10 word after reread");

      // R9: partial reset mid-fill with non-default offsets
      for (int k = 0; k < 7; k++) wr_word(200 + k);
      ae_ofs = 4'd5; af_ofs = 4'd3;
      hit_reset(1'b1);
      sweep(11, "R9 offsets 5/3");

      // R8: master reset mid-fill
      for (int k = 0; k < 9; k++) wr_word(300 + k);
      settle();
      check_flags(9, "R8 before reset");
      hit_reset(1'b0);
      wr_word(9'h0F0);
      settle();
      rd_word("R8 first word after reset");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule